// File: doc/BRIEF.md
# Sleep-Mode Entry and Recovery Controller

This block sits between the command interface of a synchronous memory and its core. It accepts an asynchronous, active-high sleep request and synchronises it with a two-stage flop chain. It then runs a fixed entry window before it declares the memory asleep. While asleep it blocks every command and address going to the core. It also masks the read-data output, so the output enable is low and the data is zero. The core's contents are not touched, so stored state survives the sleep period.

The request can fall during the entry window or while the memory is asleep. In either case the controller opens a recovery window of fixed length before normal operation resumes. During both the entry and recovery windows, read and deselect commands reach the core but write commands are dropped. A dropped write raises a one-cycle error flag. If the request falls during the entry window, entry is abandoned and the controller goes straight to recovery.

Top module: `sleep_guard`

## Requirements
- R1: The sleep request passes through two synchroniser flops. The restriction flag first rises at the third rising edge after the request is first sampled high, and no earlier.
- R2: The entry window lasts ENTRY_CYCLES (default 2) cycles, with cmdRestrict high. After it, sleepActive, inputIgnore and outputDisable are all high together.
- R3: While asleep, coreValid and coreWrite stay low and coreAddr is all zeros, whatever the command inputs are.
- R4: While asleep, qEn is low and qData is zero. When awake, qEn follows rdDataValid and qData equals rdData.
- R5: After the request is seen low through the synchroniser, a recovery window of EXIT_CYCLES (default 2) cycles follows, with cmdRestrict high. After it, all flags are low.
- R6: Inside the entry and recovery windows, a read command (cmdValid=1, cmdWrite=0) reaches the core, and a write command (cmdValid=1, cmdWrite=1) gives coreValid=0.
- R7: writeErr is high for exactly the cycle after a cycle in which a write command was offered while cmdRestrict was high. Otherwise it is low.
- R8: If the synchronised request falls during the entry window, entry ends and the recovery window starts. sleepActive never rises.
- R9: While reset is held (rstN low), and in the first cycle after it is released, all flags are low and commands pass to the core unchanged.
- R10: sleepActive and cmdRestrict are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| sleepReq | input | 1 | Asynchronous sleep request, active high |
| cmdValid | input | 1 | Command present on this cycle |
| cmdWrite | input | 1 | Command is a write (1) or a read (0) |
| cmdAddr | input | ADDR_W | Command address |
| rdData | input | DATA_W | Read data from the core's output register |
| rdDataValid | input | 1 | Core is presenting read data |
| coreValid | output | 1 | Gated command valid to the core |
| coreWrite | output | 1 | Gated write strobe to the core |
| coreAddr | output | ADDR_W | Gated address to the core |
| qData | output | DATA_W | Read data towards the pins, zero when disabled |
| qEn | output | 1 | Output-driver enable; low means high impedance |
| inputIgnore | output | 1 | Inputs other than the request are being ignored |
| outputDisable | output | 1 | Outputs are forced to high impedance |
| sleepActive | output | 1 | Memory is in the sleep state |
| cmdRestrict | output | 1 | Entry or recovery window; only reads and deselects are legal |
| writeErr | output | 1 | One-cycle flag: a write was offered inside a window |

## Verification
The main sequence raises the request and holds it across a full entry and sleep. It then drops the request and runs through recovery, with a mix of reads, writes and idle cycles on every cycle. This separates the awake, entry, asleep and recovery behaviours of command gating, and it also separates the error flag's one-cycle lag from the state change. A short request pulse that falls inside the entry window separates abandoned entry from full sleep. A read-data pattern offered asleep and awake shows the output masking. Writes offered on the exact cycles before and after each window edge pin down the boundaries of the error flag.

// File: rtl/sleep_guard_pkg.sv
package sleep_guard_pkg;

  typedef enum logic [1:0] {
    ST_AWAKE   = 2'd0,
    ST_ENTER   = 2'd1,
    ST_ASLEEP  = 2'd2,
    ST_RECOVER = 2'd3
  } pwrState_t;

  typedef struct packed {
    logic ignoreIn;
    logic disableOut;
    logic restrictCmd;
  } ctrlStrobe_t;

endpackage

// File: rtl/sleep_sync.sv
module sleep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] chainQ;

  generate
    genvar gi;
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chainQ[gi] <= 1'b0;
          else       chainQ[gi] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chainQ[gi] <= 1'b0;
          else       chainQ[gi] <= chainQ[gi-1];
        end
      end
    end
  endgenerate

  assign syncOut = chainQ[STAGES-1];

endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
  import sleep_guard_pkg::*;
#(
  parameter int ENTRY_CYCLES = 2,
  parameter int EXIT_CYCLES  = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqSync,
  output ctrlStrobe_t strobes,
  output logic        sleepActive,
  output logic        cmdRestrict
);

  localparam int MAX_WIN = (ENTRY_CYCLES > EXIT_CYCLES) ? ENTRY_CYCLES : EXIT_CYCLES;
  localparam int CNT_W   = (MAX_WIN > 1) ? $clog2(MAX_WIN) : 1;
  localparam logic [CNT_W-1:0] ENTRY_LOAD = CNT_W'(ENTRY_CYCLES - 1);
  localparam logic [CNT_W-1:0] EXIT_LOAD  = CNT_W'(EXIT_CYCLES - 1);

  pwrState_t        stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;

  always_comb begin
    stateD = stateQ;
    cntD   = cntQ;
    unique case (stateQ)
      ST_AWAKE: begin
        if (reqSync) begin
          stateD = ST_ENTER;
          cntD   = ENTRY_LOAD;
        end
      end
      ST_ENTER: begin
        if (!reqSync) begin
          stateD = ST_RECOVER;
          cntD   = EXIT_LOAD;
        end else if (cntQ == '0) begin
          stateD = ST_ASLEEP;
        end else begin
          cntD = cntQ - 1'b1;
        end
      end
      ST_ASLEEP: begin
        if (!reqSync) begin
          stateD = ST_RECOVER;
          cntD   = EXIT_LOAD;
        end
      end
      ST_RECOVER: begin
        if (reqSync) begin
          stateD = ST_ENTER;
          cntD   = ENTRY_LOAD;
        end else if (cntQ == '0) begin
          stateD = ST_AWAKE;
        end else begin
          cntD = cntQ - 1'b1;
        end
      end
      default: begin
        stateD = ST_AWAKE;
        cntD   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_AWAKE;
      cntQ   <= '0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
    end
  end

  assign strobes.ignoreIn    = (stateQ == ST_ASLEEP);
  assign strobes.disableOut  = (stateQ == ST_ASLEEP);
  assign strobes.restrictCmd = (stateQ == ST_ENTER) || (stateQ == ST_RECOVER);
  assign sleepActive         = (stateQ == ST_ASLEEP);
  assign cmdRestrict         = strobes.restrictCmd;

  // R10
  excl_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(sleepActive && cmdRestrict));

  // R1
  awake_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sleepActive && !cmdRestrict && !reqSync) |=> (!sleepActive && !cmdRestrict));

  // R2
  sleep_after_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sleepActive) |-> $past(cmdRestrict));

  // R5
  wake_via_recover_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sleepActive) |-> cmdRestrict);

endmodule

// File: rtl/sleep_datapath.sv
module sleep_datapath
  import sleep_guard_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobes,
  input  logic              cmdValid,
  input  logic              cmdWrite,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] rdData,
  input  logic              rdDataValid,
  output logic              coreValid,
  output logic              coreWrite,
  output logic [ADDR_W-1:0] coreAddr,
  output logic [DATA_W-1:0] qData,
  output logic              qEn,
  output logic              writeErr
);

  logic illegalWrite;
  logic errQ;

  assign illegalWrite = strobes.restrictCmd && cmdValid && cmdWrite;

  assign coreValid = cmdValid && !strobes.ignoreIn && !illegalWrite;
  assign coreWrite = coreValid && cmdWrite;
  assign coreAddr  = strobes.ignoreIn ? '0 : cmdAddr;

  assign qEn   = rdDataValid && !strobes.disableOut;
  assign qData = strobes.disableOut ? '0 : rdData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errQ <= 1'b0;
    else       errQ <= illegalWrite;
  end

  assign writeErr = errQ;

  // R3
  asleep_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ignoreIn |-> (!coreValid && !coreWrite && coreAddr == '0));

  // R4
  out_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.disableOut |-> (!qEn && qData == '0));

  // R6
  window_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.restrictCmd && cmdWrite) |-> !coreWrite);

endmodule

// File: rtl/sleep_guard.sv
module sleep_guard
  import sleep_guard_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 32,
  parameter int SYNC_STAGES  = 2,
  parameter int ENTRY_CYCLES = 2,
  parameter int EXIT_CYCLES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sleepReq,
  input  logic              cmdValid,
  input  logic              cmdWrite,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] rdData,
  input  logic              rdDataValid,
  output logic              coreValid,
  output logic              coreWrite,
  output logic [ADDR_W-1:0] coreAddr,
  output logic [DATA_W-1:0] qData,
  output logic              qEn,
  output logic              inputIgnore,
  output logic              outputDisable,
  output logic              sleepActive,
  output logic              cmdRestrict,
  output logic              writeErr
);

  logic        reqSync;
  ctrlStrobe_t strobes;

  sleep_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (sleepReq),
    .syncOut (reqSync)
  );

  sleep_ctrl #(
    .ENTRY_CYCLES (ENTRY_CYCLES),
    .EXIT_CYCLES  (EXIT_CYCLES)
  ) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .reqSync     (reqSync),
    .strobes     (strobes),
    .sleepActive (sleepActive),
    .cmdRestrict (cmdRestrict)
  );

  sleep_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .cmdValid    (cmdValid),
    .cmdWrite    (cmdWrite),
    .cmdAddr     (cmdAddr),
    .rdData      (rdData),
    .rdDataValid (rdDataValid),
    .coreValid   (coreValid),
    .coreWrite   (coreWrite),
    .coreAddr    (coreAddr),
    .qData       (qData),
    .qEn         (qEn),
    .writeErr    (writeErr)
  );

  assign inputIgnore   = strobes.ignoreIn;
  assign outputDisable = strobes.disableOut;

endmodule

// File: tb/sleep_guard_tb.sv
module sleep_guard_tb_top;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              sleepReq = 1'b0;
  logic              cmdValid = 1'b0;
  logic              cmdWrite = 1'b0;
  logic [ADDR_W-1:0] cmdAddr = 16'h5A3C;
  logic [DATA_W-1:0] rdData = 32'hCAFE_F00D;
  logic              rdDataValid = 1'b0;
  logic              coreValid, coreWrite, qEn;
  logic [ADDR_W-1:0] coreAddr;
  logic [DATA_W-1:0] qData;
  logic              inputIgnore, outputDisable, sleepActive, cmdRestrict, writeErr;

  int checks = 0;
  int fails  = 0;
  bit sawSleep;

  always #2.5 clk = ~clk;

  sleep_guard dut_i (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq),
    .cmdValid(cmdValid), .cmdWrite(cmdWrite), .cmdAddr(cmdAddr),
    .rdData(rdData), .rdDataValid(rdDataValid),
    .coreValid(coreValid), .coreWrite(coreWrite), .coreAddr(coreAddr),
    .qData(qData), .qEn(qEn), .inputIgnore(inputIgnore),
    .outputDisable(outputDisable), .sleepActive(sleepActive),
    .cmdRestrict(cmdRestrict), .writeErr(writeErr)
  );

  // Row bits: [6] req, [5] valid, [4] write, [3] exp sleep,
  // [2] exp restrict, [1] exp coreValid, [0] exp writeErr
  localparam logic [6:0] VEC [12] = '{
    7'b1110010, 7'b1100010, 7'b1110100, 7'b1110101,
    7'b1101000, 7'b1111000, 7'b0001000, 7'b0101000,
    7'b0100110, 7'b0110101, 7'b0110011, 7'b0110010
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    // R9: held in reset, then first cycle after release
    cmdValid = 1'b1;
    cmdWrite = 1'b1;
    repeat (3) @(negedge clk);
    check(!sleepActive && !cmdRestrict && !writeErr, "R9 reset flags",
          {sleepActive, cmdRestrict, writeErr}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(coreValid && coreWrite && coreAddr == cmdAddr, "R9 pass after reset",
          {coreValid, coreWrite, coreAddr}, {2'b11, cmdAddr});
    check(!inputIgnore && !outputDisable, "R9 gates open",
          {inputIgnore, outputDisable}, 0);
    cmdValid = 1'b0;
    @(negedge clk);

    // R1 R2 R3 R5 R6 R7 R10: vector walk
    for (int i = 0; i < 12; i++) begin
      sleepReq = VEC[i][6];
      cmdValid = VEC[i][5];
      cmdWrite = VEC[i][4];
      @(negedge clk);
      check(sleepActive == VEC[i][3] && inputIgnore == VEC[i][3] && outputDisable == VEC[i][3],
            $sformatf("R2 R5 sleep flags row %0d", i),
            {sleepActive, inputIgnore, outputDisable}, {3{VEC[i][3]}});
      check(cmdRestrict == VEC[i][2], $sformatf("R1 R5 restrict row %0d", i),
            cmdRestrict, VEC[i][2]);
      check(coreValid == VEC[i][1], $sformatf("R3 R6 coreValid row %0d", i),
            coreValid, VEC[i][1]);
      check(writeErr == VEC[i][0], $sformatf("R7 writeErr row %0d", i),
            writeErr, VEC[i][0]);
      check(!(sleepActive && cmdRestrict), $sformatf("R10 exclusive row %0d", i),
            {sleepActive, cmdRestrict}, {1'b0, cmdRestrict});
      if (VEC[i][3])
        check(coreAddr == '0 && !coreWrite, $sformatf("R3 addr gated row %0d", i),
              coreAddr, 0);
    end
    cmdValid = 1'b0;
    repeat (3) @(negedge clk);

    // R4: output masking asleep versus awake
    rdDataValid = 1'b1;
    @(negedge clk);
    check(qEn && qData == rdData, "R4 awake output", {qEn, qData}, {1'b1, rdData});
    sleepReq = 1'b1;
    repeat (5) @(negedge clk);
    check(sleepActive, "R2 asleep before R4 check", sleepActive, 1);
    check(!qEn && qData == '0, "R4 asleep output", {qEn, qData}, 0);
    sleepReq = 1'b0;
    repeat (5) @(negedge clk);
    check(qEn && qData == rdData && !sleepActive && !cmdRestrict, "R4 R5 wake output",
          {qEn, qData}, {1'b1, rdData});
    rdDataValid = 1'b0;
    repeat (2) @(negedge clk);

    // R8: request pulse falling inside the entry window
    sawSleep = 1'b0;
    sleepReq = 1'b1;
    repeat (2) @(negedge clk);
    sleepReq = 1'b0;
    for (int k = 3; k <= 7; k++) begin
      @(negedge clk);
      if (sleepActive) sawSleep = 1'b1;
      check(cmdRestrict == (k < 7), $sformatf("R8 restrict edge %0d", k),
            cmdRestrict, (k < 7));
    end
    check(!sawSleep, "R8 never asleep", sawSleep, 0);

    finishRun();
  end

endmodule